// File: doc/BRIEF.md
# Power-Mode Supervisory State Machine

This block is the mode controller of a supply-managing companion chip. It keeps track of the chip's operating mode. Off, Standby, Sleep and Normal are the ordinary modes. Overtemp is a protection mode. The block turns that mode into regulator enables, a CAN transceiver state, a watchdog run flag and a timed active-low reset output for the host processor.

Several things can change the mode. Supply, temperature and wake events arrive at any time. Software also writes a 2-bit mode code through a register interface, and the host can request a system reset. When more than one of these happens in the same clock cycle, one fixed order decides. A supply collapse wins first, then over-temperature entry, then the reset request, then a wake event, and a register write comes last. A write that is not a legal move from the current mode is dropped.

A reset pulse is issued when the supply comes up and when the host asks for a system reset. Its length is a number of clock cycles. A configuration input chooses the long length or the short one.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rstN` is low, and after it is released with no supply event, the block is in Off mode: `specialMode`=01, `modeCode`=00, both regulator enables low, `canMode`=00, `busHiZ` high and `rstOutN` low.
- R2: A cycle with `batPowerOff` high puts the block in Off mode on the next cycle, whatever mode it was in.
- R3: In Off mode, `batPowerOn` with `batPowerOff` low moves the block to Standby. `rstOutN` then stays low for exactly SHORT_CYCLES cycles (`cfgLongReset`=0) or LONG_CYCLES cycles (`cfgLongReset`=1), beginning in the first cycle of Standby.
- R4: In Standby, a write of code 00 keeps Standby, 01 selects Sleep, 10 selects Normal with V2 off and 11 selects Normal with V2 on. `modeCode` then reads back the written code.
- R5: In Normal mode, code 00 returns the block to Standby, and codes 10 and 11 switch V2 off and on. Code 01 is ignored.
- R6: In Sleep mode, `canWake` or `localWake` returns the block to Standby. Mode writes made in Sleep are ignored.
- R7: In Standby, `otActive` enters Overtemp (`specialMode`=10), and `otRelease` returns the block to Standby. Mode writes are ignored in Overtemp and in Off, and `otActive` has no effect outside Standby.
- R8: `sysResetReq` in Standby, Sleep or Normal moves the block to Standby and starts a reset pulse whose length is set as in R3. The request is ignored in Off and in Overtemp.
- R9: When events fall in the same cycle, the order is supply-off, then over-temperature entry, then reset request, then wake, then mode write.
- R10: The outputs depend on the mode as follows. Standby: V1 on, V2 off, `canMode`=01 when `canLowPowerCfg`=1 and 00 otherwise. Sleep: both regulators off, `canMode`=01. Normal: V1 on, V2 as selected, `canMode`=10. Off and Overtemp: both regulators off, `canMode`=00. `busHiZ` is high only in Off, and `rstOutN` is low whenever V1 is off.
- R11: `wdRun` equals `!wdDisablePin && wdModeBit` in Standby and `!wdDisablePin` in Normal. It is 0 in every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| batPowerOff | input | 1 | Battery below power-off level |
| batPowerOn | input | 1 | Battery above power-on level |
| otActive | input | 1 | Over-temperature activation |
| otRelease | input | 1 | Temperature below release level |
| canWake | input | 1 | CAN bus wake event |
| localWake | input | 1 | Local wake event |
| mcWrite | input | 1 | Mode-code write strobe |
| mcCode | input | 2 | Mode code written |
| sysResetReq | input | 1 | System reset request |
| cfgLongReset | input | 1 | 1 selects the long reset pulse |
| canLowPowerCfg | input | 1 | Standby CAN state: 1 low-power with wake detection, 0 off |
| wdDisablePin | input | 1 | Watchdog disable pin level |
| wdModeBit | input | 1 | Watchdog timeout-mode control bit |
| v1En | output | 1 | V1 regulator enable |
| v2En | output | 1 | V2 regulator enable |
| canMode | output | 2 | CAN state: 00 off, 01 low-power, 10 active |
| busHiZ | output | 1 | Bus outputs high-impedance |
| wdRun | output | 1 | Watchdog runs in timeout mode |
| rstOutN | output | 1 | Active-low reset to host |
| modeCode | output | 2 | Mode readback: 00 Standby, 01 Sleep, 10/11 Normal with V2 off/on |
| specialMode | output | 2 | 00 ordinary mode, 01 Off, 10 Overtemp |

## Verification
Every mode register change reaches the status and enable outputs one clock after the triggering event, with no extra stage in between. A wrong mode or a wrong V2 flag therefore shows on `modeCode`, `specialMode` and the regulator enables in the very next cycle. A reset counter loaded with the wrong value, or stepped wrongly, only shows at the far end of the pulse, as `rstOutN` rising too early or too late. For that reason the bench measures the whole pulse width in both lengths, after power-up and after a system reset. Priority faults only appear when events collide, so the bench drives several of them into a single cycle.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    MODE_OFF   = 3'd0,
    MODE_STBY  = 3'd1,
    MODE_SLEEP = 3'd2,
    MODE_NORM  = 3'd3,
    MODE_HOT   = 3'd4
  } pwrMode_e;

  typedef struct packed {
    logic pulseStart;
    logic pulseLong;
  } ctrlStrobe_t;

  localparam logic [1:0] CAN_OFF    = 2'b00;
  localparam logic [1:0] CAN_LOWPWR = 2'b01;
  localparam logic [1:0] CAN_ACTIVE = 2'b10;

  localparam logic [1:0] SPECIAL_NONE = 2'b00;
  localparam logic [1:0] SPECIAL_OFF  = 2'b01;
  localparam logic [1:0] SPECIAL_HOT  = 2'b10;

endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        batPowerOff,
  input  logic        batPowerOn,
  input  logic        otActive,
  input  logic        otRelease,
  input  logic        canWake,
  input  logic        localWake,
  input  logic        mcWrite,
  input  logic [1:0]  mcCode,
  input  logic        sysResetReq,
  input  logic        cfgLongReset,
  output pwrMode_e    curMode,
  output logic        v2Sel,
  output ctrlStrobe_t strobe
);

  pwrMode_e nextMode;
  logic     nextV2;

  // Event resolution: supply-off > over-temperature > reset > wake > write
  always_comb begin
    nextMode          = curMode;
    nextV2            = v2Sel;
    strobe.pulseStart = 1'b0;
    strobe.pulseLong  = cfgLongReset;
    if (batPowerOff) begin
      nextMode = MODE_OFF;
      nextV2   = 1'b0;
    end else begin
      unique case (curMode)
        MODE_OFF: begin
          if (batPowerOn) begin
            nextMode          = MODE_STBY;
            strobe.pulseStart = 1'b1;
          end
        end
        MODE_HOT: begin
          if (otRelease) nextMode = MODE_STBY;
        end
        default: begin
          if (curMode == MODE_STBY && otActive) begin
            nextMode = MODE_HOT;
          end else if (sysResetReq) begin
            nextMode          = MODE_STBY;
            nextV2            = 1'b0;
            strobe.pulseStart = 1'b1;
          end else if (curMode == MODE_SLEEP) begin
            if (canWake || localWake) nextMode = MODE_STBY;
          end else if (mcWrite) begin
            if (curMode == MODE_STBY) begin
              unique case (mcCode)
                2'b00: nextMode = MODE_STBY;
                2'b01: nextMode = MODE_SLEEP;
                default: begin
                  nextMode = MODE_NORM;
                  nextV2   = mcCode[0];
                end
              endcase
            end else begin
              // Normal mode: sleep request is not a legal move
              unique case (mcCode)
                2'b00: begin
                  nextMode = MODE_STBY;
                  nextV2   = 1'b0;
                end
                2'b01: nextMode = MODE_NORM;
                default: nextV2 = mcCode[0];
              endcase
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curMode <= MODE_OFF;
      v2Sel   <= 1'b0;
    end else begin
      curMode <= nextMode;
      v2Sel   <= nextV2;
    end
  end

endmodule

// File: rtl/pwr_mode_outputs.sv
module pwr_mode_outputs
  import pwr_mode_pkg::*;
#(
  parameter int SHORT_CYCLES = 4,
  parameter int LONG_CYCLES  = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  pwrMode_e    curMode,
  input  logic        v2Sel,
  input  ctrlStrobe_t strobe,
  input  logic        canLowPowerCfg,
  input  logic        wdDisablePin,
  input  logic        wdModeBit,
  output logic        v1En,
  output logic        v2En,
  output logic [1:0]  canMode,
  output logic        busHiZ,
  output logic        wdRun,
  output logic        rstOutN,
  output logic [1:0]  modeCode,
  output logic [1:0]  specialMode
);

  localparam int MAX_CYCLES = (LONG_CYCLES > SHORT_CYCLES) ? LONG_CYCLES : SHORT_CYCLES;
  localparam int CNT_W      = $clog2(MAX_CYCLES + 1);

  logic [CNT_W-1:0] pulseCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strobe.pulseStart) begin
      pulseCnt <= strobe.pulseLong ? CNT_W'(LONG_CYCLES) : CNT_W'(SHORT_CYCLES);
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  always_comb begin
    v1En        = 1'b0;
    v2En        = 1'b0;
    canMode     = CAN_OFF;
    busHiZ      = 1'b0;
    wdRun       = 1'b0;
    modeCode    = 2'b00;
    specialMode = SPECIAL_NONE;
    unique case (curMode)
      MODE_OFF: begin
        busHiZ      = 1'b1;
        specialMode = SPECIAL_OFF;
      end
      MODE_STBY: begin
        v1En    = 1'b1;
        canMode = canLowPowerCfg ? CAN_LOWPWR : CAN_OFF;
        wdRun   = !wdDisablePin && wdModeBit;
      end
      MODE_SLEEP: begin
        canMode  = CAN_LOWPWR;
        modeCode = 2'b01;
      end
      MODE_NORM: begin
        v1En     = 1'b1;
        v2En     = v2Sel;
        canMode  = CAN_ACTIVE;
        wdRun    = !wdDisablePin;
        modeCode = {1'b1, v2Sel};
      end
      default: specialMode = SPECIAL_HOT;
    endcase
    rstOutN = v1En && (pulseCnt == '0);
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int SHORT_CYCLES = 4,
  parameter int LONG_CYCLES  = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       batPowerOff,
  input  logic       batPowerOn,
  input  logic       otActive,
  input  logic       otRelease,
  input  logic       canWake,
  input  logic       localWake,
  input  logic       mcWrite,
  input  logic [1:0] mcCode,
  input  logic       sysResetReq,
  input  logic       cfgLongReset,
  input  logic       canLowPowerCfg,
  input  logic       wdDisablePin,
  input  logic       wdModeBit,
  output logic       v1En,
  output logic       v2En,
  output logic [1:0] canMode,
  output logic       busHiZ,
  output logic       wdRun,
  output logic       rstOutN,
  output logic [1:0] modeCode,
  output logic [1:0] specialMode
);

  pwrMode_e    curMode;
  logic        v2Sel;
  ctrlStrobe_t strobe;

  pwr_mode_fsm u_fsm (
    .clk          (clk),
    .rstN         (rstN),
    .batPowerOff  (batPowerOff),
    .batPowerOn   (batPowerOn),
    .otActive     (otActive),
    .otRelease    (otRelease),
    .canWake      (canWake),
    .localWake    (localWake),
    .mcWrite      (mcWrite),
    .mcCode       (mcCode),
    .sysResetReq  (sysResetReq),
    .cfgLongReset (cfgLongReset),
    .curMode      (curMode),
    .v2Sel        (v2Sel),
    .strobe       (strobe)
  );

  pwr_mode_outputs #(
    .SHORT_CYCLES (SHORT_CYCLES),
    .LONG_CYCLES  (LONG_CYCLES)
  ) u_out (
    .clk            (clk),
    .rstN           (rstN),
    .curMode        (curMode),
    .v2Sel          (v2Sel),
    .strobe         (strobe),
    .canLowPowerCfg (canLowPowerCfg),
    .wdDisablePin   (wdDisablePin),
    .wdModeBit      (wdModeBit),
    .v1En           (v1En),
    .v2En           (v2En),
    .canMode        (canMode),
    .busHiZ         (busHiZ),
    .wdRun          (wdRun),
    .rstOutN        (rstOutN),
    .modeCode       (modeCode),
    .specialMode    (specialMode)
  );

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       batPowerOff,
  input logic       batPowerOn,
  input logic       otActive,
  input logic       canWake,
  input logic       localWake,
  input logic       sysResetReq,
  input logic       v1En,
  input logic       v2En,
  input logic [1:0] canMode,
  input logic       busHiZ,
  input logic       wdRun,
  input logic       rstOutN,
  input logic [1:0] modeCode,
  input logic [1:0] specialMode
);

  logic inStandby;
  assign inStandby = (specialMode == 2'b00) && (modeCode == 2'b00);

  assert_off_forced_R2: assert property (@(posedge clk) disable iff (!rstN)
    batPowerOff |=> specialMode == 2'b01);

  assert_off_rails_R10: assert property (@(posedge clk) disable iff (!rstN)
    specialMode == 2'b01 |-> (!v1En && !v2En && busHiZ && canMode == 2'b00 && !rstOutN));

  assert_powerup_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    (specialMode == 2'b01 && batPowerOn && !batPowerOff)
      |=> (inStandby && !rstOutN));

  assert_wake_return_R6: assert property (@(posedge clk) disable iff (!rstN)
    (specialMode == 2'b00 && modeCode == 2'b01 && (canWake || localWake) && !batPowerOff)
      |=> inStandby);

  assert_hot_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inStandby && otActive && !batPowerOff) |=> specialMode == 2'b10);

  assert_reset_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    (specialMode == 2'b00 && sysResetReq && !batPowerOff && !(inStandby && otActive))
      |=> (inStandby && !rstOutN));

  assert_v2_status_R10: assert property (@(posedge clk) disable iff (!rstN)
    v2En |-> (modeCode == 2'b11 && v1En));

  assert_wd_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !v1En |-> !wdRun);

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .batPowerOff (batPowerOff),
  .batPowerOn  (batPowerOn),
  .otActive    (otActive),
  .canWake     (canWake),
  .localWake   (localWake),
  .sysResetReq (sysResetReq),
  .v1En        (v1En),
  .v2En        (v2En),
  .canMode     (canMode),
  .busHiZ      (busHiZ),
  .wdRun       (wdRun),
  .rstOutN     (rstOutN),
  .modeCode    (modeCode),
  .specialMode (specialMode)
);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;

  localparam int SHORT_N = 4;
  localparam int LONG_N  = 32;
  // bench mode numbering
  localparam int B_OFF = 0, B_STBY = 1, B_SLEEP = 2, B_NORMA = 3, B_NORMB = 4, B_HOT = 5;

  logic clk = 1'b0;
  logic rstN;
  logic batPowerOff, batPowerOn, otActive, otRelease, canWake, localWake;
  logic mcWrite, sysResetReq, cfgLongReset, canLowPowerCfg, wdDisablePin, wdModeBit;
  logic [1:0] mcCode;
  logic v1En, v2En, busHiZ, wdRun, rstOutN;
  logic [1:0] canMode, modeCode, specialMode;

  int passCnt = 0;
  int totalCnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl #(.SHORT_CYCLES(SHORT_N), .LONG_CYCLES(LONG_N)) u_dut (
    .clk(clk), .rstN(rstN), .batPowerOff(batPowerOff), .batPowerOn(batPowerOn),
    .otActive(otActive), .otRelease(otRelease), .canWake(canWake), .localWake(localWake),
    .mcWrite(mcWrite), .mcCode(mcCode), .sysResetReq(sysResetReq),
    .cfgLongReset(cfgLongReset), .canLowPowerCfg(canLowPowerCfg),
    .wdDisablePin(wdDisablePin), .wdModeBit(wdModeBit),
    .v1En(v1En), .v2En(v2En), .canMode(canMode), .busHiZ(busHiZ), .wdRun(wdRun),
    .rstOutN(rstOutN), .modeCode(modeCode), .specialMode(specialMode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    totalCnt++;
    if (act === exp) passCnt++;
    else $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
  endtask

  // {modeCode, specialMode, v1En, v2En, canMode, busHiZ}
  function automatic logic [8:0] expVec(input int m);
    case (m)
      B_OFF:   return {2'b00, 2'b01, 1'b0, 1'b0, 2'b00, 1'b1};
      B_STBY:  return {2'b00, 2'b00, 1'b1, 1'b0, canLowPowerCfg ? 2'b01 : 2'b00, 1'b0};
      B_SLEEP: return {2'b01, 2'b00, 1'b0, 1'b0, 2'b01, 1'b0};
      B_NORMA: return {2'b10, 2'b00, 1'b1, 1'b0, 2'b10, 1'b0};
      B_NORMB: return {2'b11, 2'b00, 1'b1, 1'b1, 2'b10, 1'b0};
      default: return {2'b00, 2'b10, 1'b0, 1'b0, 2'b00, 1'b0};
    endcase
  endfunction

  function automatic int afterWrite(input int m, input int c);
    if (m == B_STBY) return B_STBY + c;
    if (m == B_NORMA || m == B_NORMB) return (c == 0) ? B_STBY : ((c == 1) ? m : B_STBY + c);
    return m;
  endfunction

  task automatic checkMode(input string req, input int m);
    check(req, 32'({modeCode, specialMode, v1En, v2En, canMode, busHiZ}), 32'(expVec(m)));
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clearEvents();
    batPowerOff = 0; otActive = 0; otRelease = 0; canWake = 0; localWake = 0;
    mcWrite = 0; mcCode = 0; sysResetReq = 0;
  endtask

  task automatic writeCode(input int c);
    mcWrite = 1; mcCode = 2'(c);
    cyc();
    mcWrite = 0;
  endtask

  // counts rstOutN low cycles from the current sample onward
  task automatic measurePulse(output int lows);
    lows = 0;
    while (!rstOutN && lows < 100) begin
      lows++;
      cyc();
    end
  endtask

  // supply collapse then recovery; ends in Standby after the pulse
  task automatic freshStandby(input logic longSel, output int lows);
    cfgLongReset = longSel;
    batPowerOn = 1; batPowerOff = 1;
    cyc();
    batPowerOff = 0;
    cyc();
    measurePulse(lows);
  endtask

  task automatic reachMode(input int m);
    int lows;
    freshStandby(1'b0, lows);
    if (m == B_SLEEP) writeCode(1);
    if (m == B_NORMA) writeCode(2);
    if (m == B_NORMB) writeCode(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      totalCnt++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", passCnt, totalCnt);
      $finish;
    end
  end

  initial begin
    int lows;
    rstN = 0; clearEvents(); batPowerOn = 0; cfgLongReset = 0;
    canLowPowerCfg = 1; wdDisablePin = 0; wdModeBit = 1;
    repeat (3) cyc();
    // R1: reset state
    checkMode("R1 reset state", B_OFF);
    check("R1 rstOutN in reset", 32'(rstOutN), 0);
    rstN = 1;
    cyc();
    checkMode("R1 after release", B_OFF);
    // R7: mode writes ignored in Off
    writeCode(2);
    checkMode("R7 write ignored in Off", B_OFF);

    // R3: power-up pulse widths
    for (int l = 0; l < 2; l++) begin
      freshStandby(l[0], lows);
      check("R3 powerup pulse width", 32'(lows), (l == 1) ? LONG_N : SHORT_N);
      checkMode("R3 Standby after powerup", B_STBY);
    end

    // R4 R5 R6: sweep start mode x written code
    for (int m = B_STBY; m <= B_NORMB; m++) begin
      for (int c = 0; c < 4; c++) begin
        reachMode(m);
        writeCode(c);
        checkMode((m == B_STBY) ? "R4 write from Standby" :
                  (m == B_SLEEP) ? "R6 write ignored in Sleep" : "R5 write from Normal",
                  afterWrite(m, c));
      end
    end

    // R6: both wake sources
    for (int w = 0; w < 2; w++) begin
      reachMode(B_SLEEP);
      canWake = (w == 0); localWake = (w == 1);
      cyc();
      clearEvents();
      checkMode("R6 wake from Sleep", B_STBY);
    end

    // R2: supply-off from every mode
    for (int m = B_STBY; m <= B_HOT; m++) begin
      reachMode((m == B_HOT) ? B_STBY : m);
      if (m == B_HOT) begin otActive = 1; cyc(); otActive = 0; end
      batPowerOff = 1;
      cyc();
      batPowerOff = 0; batPowerOn = 0;
      checkMode("R2 supply-off forces Off", B_OFF);
      batPowerOn = 1;
    end

    // R7: overtemp entry, ignored events, release
    reachMode(B_STBY);
    otActive = 1; cyc(); otActive = 0;
    checkMode("R7 overtemp entry", B_HOT);
    check("R10 rstOutN low in Overtemp", 32'(rstOutN), 0);
    writeCode(2);
    checkMode("R7 write ignored in Overtemp", B_HOT);
    sysResetReq = 1; cyc(); sysResetReq = 0;
    checkMode("R8 reset ignored in Overtemp", B_HOT);
    otRelease = 1; cyc(); otRelease = 0;
    checkMode("R7 release to Standby", B_STBY);
    reachMode(B_SLEEP);
    otActive = 1; cyc(); otActive = 0;
    checkMode("R7 otActive no effect in Sleep", B_SLEEP);

    // R8: reset request from powered modes, both widths
    for (int m = B_STBY; m <= B_NORMB; m++) begin
      for (int l = 0; l < 2; l++) begin
        reachMode(m);
        cfgLongReset = l[0];
        sysResetReq = 1; cyc(); sysResetReq = 0;
        checkMode("R8 reset returns Standby", B_STBY);
        measurePulse(lows);
        check("R8 reset pulse width", 32'(lows), (l == 1) ? LONG_N : SHORT_N);
      end
    end

    // R9: collisions
    reachMode(B_STBY);
    batPowerOff = 1; otActive = 1; sysResetReq = 1; mcWrite = 1; mcCode = 2'b10;
    cyc(); clearEvents(); batPowerOn = 0;
    checkMode("R9 supply-off wins", B_OFF);
    batPowerOn = 1;
    reachMode(B_STBY);
    otActive = 1; sysResetReq = 1; mcWrite = 1; mcCode = 2'b11;
    cyc(); clearEvents();
    checkMode("R9 overtemp beats reset", B_HOT);
    reachMode(B_SLEEP);
    cfgLongReset = 0; sysResetReq = 1; canWake = 1;
    cyc(); clearEvents();
    measurePulse(lows);
    check("R9 reset beats wake", 32'(lows), SHORT_N);
    reachMode(B_SLEEP);
    localWake = 1; mcWrite = 1; mcCode = 2'b11;
    cyc(); clearEvents();
    checkMode("R9 wake beats write", B_STBY);
    reachMode(B_NORMA);
    sysResetReq = 1; mcWrite = 1; mcCode = 2'b11;
    cyc(); clearEvents();
    checkMode("R9 reset beats write", B_STBY);

    // R10: Standby CAN state follows config
    reachMode(B_STBY);
    for (int s = 0; s < 2; s++) begin
      canLowPowerCfg = s[0];
      #1;
      check("R10 Standby canMode", 32'(canMode), (s == 1) ? 1 : 0);
    end
    canLowPowerCfg = 1;

    // R11: watchdog sweep in Standby, Normal and Sleep
    for (int m = B_STBY; m <= B_NORMB; m++) begin
      reachMode(m);
      for (int k = 0; k < 4; k++) begin
        wdDisablePin = k[1]; wdModeBit = k[0];
        #1;
        check("R11 watchdog run", 32'(wdRun),
              (m == B_STBY) ? 32'(!k[1] && k[0]) : (m == B_SLEEP) ? 0 : 32'(!k[1]));
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

endmodule